// File: doc/BRIEF.md
# Low-Power State Sequencer

This block decides when the core clock, the peripheral clock and the oscillator of a small 8-bit microcontroller may run. Software asks for a low-power state through two request lines that come from a control register. With the idle request, only the core clock stops. With the power-down request, every clock stops and the oscillator is switched off. The block also drives the core reset. It holds that reset until the oscillator has run for a set number of cycles, so the clock is stable when the core starts.

The two states are left in different ways. Idle ends when an interrupt is both pending and enabled, or when the external reset is asserted. Power-down ends only through the external reset. If reset ends idle, the core runs for a few more cycles before the internal reset takes over. During that window the block blocks RAM access but leaves port access alone. The block produces only the clock enables, the oscillator enable, the RAM inhibit, the core reset and two state flags. It does not hold RAM or register contents.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Once `rst_ni` is released, `core_rst_o`=1 and `osc_en_o`=1. The clock enables start at 0 and turn on in the cycle after the settle counter reaches `SETTLE_CYC`. `core_rst_o` stays high for `SETTLE_CYC`+1 cycles in all. After that the block is running with every enable at 1 and both flags at 0.
- R2: If `req_pd_i` and `req_idle_i` are both high in the same running cycle, power-down is entered and idle is not.
- R3: A running cycle with `req_idle_i` high enters idle in the next cycle. In idle, `cpu_clk_en_o`=0, `per_clk_en_o`=1, `osc_en_o`=1 and `idle_o`=1.
- R4: In idle, an interrupt line that is both pending and enabled returns the block to running in the next cycle.
- R5: In idle, a pending interrupt whose enable bit is 0 has no effect, and the block stays in idle.
- R6: In power-down, `cpu_clk_en_o`, `per_clk_en_o` and `osc_en_o` are all 0 and `pd_o`=1. Interrupts have no effect, even when they are pending and enabled.
- R7: If `ext_rst_i` is sampled high in power-down, the oscillator is enabled in the next cycle. `core_rst_o` then stays high for `SETTLE_CYC`+1 cycles, counted from that enable.
- R8: `core_rst_o` stays high for as long as `ext_rst_i` is high. It drops in the cycle after `ext_rst_i` is sampled low, provided the oscillator has settled.
- R9: If `ext_rst_i` is sampled high in idle, the block enters a window of `DRAIN_CYC` cycles. In that window `cpu_clk_en_o`=1, `ram_inhibit_o`=1 and `core_rst_o`=0. After the window, core reset follows.
- R10: In idle, if the external reset and an enabled interrupt arrive in the same cycle, the reset wins and the inhibit window of R9 is entered.
- R11: Entry requests are acted on only while running. A request seen in idle or in power-down leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_i | input | 1 | External hardware reset, synchronised, active high |
| req_idle_i | input | 1 | Idle request bit from the control register |
| req_pd_i | input | 1 | Power-down request bit from the control register |
| irq_pend_i | input | NUM_IRQ | Interrupt pending flags |
| irq_en_i | input | NUM_IRQ | Interrupt enable mask |
| cpu_clk_en_o | output | 1 | Core clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| ram_inhibit_o | output | 1 | Blocks RAM access during the idle-exit window |
| core_rst_o | output | 1 | Core reset, active high |
| idle_o | output | 1 | Idle state flag |
| pd_o | output | 1 | Power-down state flag |

## Verification
There are two places where two functions of the block meet in the same cycle. In idle, an interrupt wake and an external reset can arrive together. In the running state, the idle request and the power-down request can be set together. The bench raises each pair in the same cycle and checks the output vector in the following cycles. For the first pair it expects the inhibit window and then core reset, with no return to running. For the second pair it expects power-down with the idle flag low.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    ST_RESET,
    ST_RUN,
    ST_IDLE,
    ST_PD,
    ST_DRAIN
  } pwr_state_e;
endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] irq_pend_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  output logic               wake_o
);
  logic [NUM_IRQ-1:0] armed;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    assign armed[g] = irq_pend_i[g] & irq_en_i[g];
  end

  assign wake_o = |armed;
endmodule

// File: rtl/pwr_osc_timer.sv
module pwr_osc_timer #(
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_en_i,
  output logic settled_o
);
  localparam int unsigned CntW = $clog2(SETTLE_CYC + 1);
  localparam logic [CntW-1:0] CntMax = CntW'(SETTLE_CYC);

  logic [CntW-1:0] cnt_q;

  // count restarts whenever the oscillator is off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!osc_en_i)     cnt_q <= '0;
    else if (cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
  end

  assign settled_o = (cnt_q == CntMax);

  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CntMax);
  assert_cnt_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_i |=> !settled_o);
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_pkg::*;
#(
  parameter int unsigned DRAIN_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_i,
  input  logic req_idle_i,
  input  logic req_pd_i,
  input  logic wake_i,
  input  logic settled_i,
  output logic cpu_clk_en_o,
  output logic per_clk_en_o,
  output logic osc_en_o,
  output logic ram_inhibit_o,
  output logic core_rst_o,
  output logic idle_o,
  output logic pd_o
);
  localparam int unsigned DrW = (DRAIN_CYC > 1) ? $clog2(DRAIN_CYC) : 1;
  localparam logic [DrW-1:0] DrLast = DrW'(DRAIN_CYC - 1);

  pwr_state_e      state_q, state_d;
  logic [DrW-1:0]  dcnt_q, dcnt_d;

  always_comb begin
    state_d = state_q;
    dcnt_d  = dcnt_q;
    unique case (state_q)
      ST_RESET: if (!ext_rst_i && settled_i) state_d = ST_RUN;
      ST_RUN: begin
        if (ext_rst_i)       state_d = ST_RESET;
        else if (req_pd_i)   state_d = ST_PD;   // power-down wins
        else if (req_idle_i) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (ext_rst_i) begin
          state_d = ST_DRAIN;
          dcnt_d  = '0;
        end else if (wake_i) begin
          state_d = ST_RUN;
        end
      end
      ST_PD: if (ext_rst_i) state_d = ST_RESET;
      ST_DRAIN: begin
        if (dcnt_q == DrLast) state_d = ST_RESET;
        else                  dcnt_d  = dcnt_q + 1'b1;
      end
      default: state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RESET;
      dcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      dcnt_q  <= dcnt_d;
    end
  end

  always_comb begin
    cpu_clk_en_o  = 1'b0;
    per_clk_en_o  = 1'b0;
    osc_en_o      = 1'b1;
    ram_inhibit_o = 1'b0;
    core_rst_o    = 1'b0;
    unique case (state_q)
      ST_RESET: begin
        core_rst_o   = 1'b1;
        cpu_clk_en_o = settled_i;
        per_clk_en_o = settled_i;
      end
      ST_RUN: begin
        cpu_clk_en_o = 1'b1;
        per_clk_en_o = 1'b1;
      end
      ST_IDLE: per_clk_en_o = 1'b1;
      ST_PD:   osc_en_o = 1'b0;
      ST_DRAIN: begin
        cpu_clk_en_o  = 1'b1;
        per_clk_en_o  = 1'b1;
        ram_inhibit_o = 1'b1;  // ports still reachable
      end
      default: core_rst_o = 1'b1;
    endcase
  end

  assign idle_o = (state_q == ST_IDLE);
  assign pd_o   = (state_q == ST_PD);

  assert_pd_prio_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && req_pd_i && !ext_rst_i) |=> pd_o);
  assert_idle_wake_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && wake_i && !ext_rst_i) |=> cpu_clk_en_o && !core_rst_o && !idle_o);
  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && !wake_i && !ext_rst_i) |=> idle_o);
  assert_pd_no_wake_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_o && !ext_rst_i) |=> pd_o);
  assert_settle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_rst_o && !settled_i) |=> core_rst_o);
  assert_ext_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_rst_o && ext_rst_i) |=> core_rst_o);
  assert_inhibit_window_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_inhibit_o |-> (cpu_clk_en_o && !core_rst_o));
  assert_rst_prio_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && ext_rst_i) |=> ram_inhibit_o);
  assert_flags_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({idle_o, pd_o, core_rst_o, ram_inhibit_o}));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int unsigned NUM_IRQ    = 8,
  parameter int unsigned SETTLE_CYC = 16,
  parameter int unsigned DRAIN_CYC  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_rst_i,
  input  logic               req_idle_i,
  input  logic               req_pd_i,
  input  logic [NUM_IRQ-1:0] irq_pend_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  output logic               cpu_clk_en_o,
  output logic               per_clk_en_o,
  output logic               osc_en_o,
  output logic               ram_inhibit_o,
  output logic               core_rst_o,
  output logic               idle_o,
  output logic               pd_o
);
  logic wake;
  logic settled;

  pwr_wake_detect #(.NUM_IRQ(NUM_IRQ)) i_wake (
    .irq_pend_i (irq_pend_i),
    .irq_en_i   (irq_en_i),
    .wake_o     (wake)
  );

  pwr_osc_timer #(.SETTLE_CYC(SETTLE_CYC)) i_osc_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .osc_en_i  (osc_en_o),
    .settled_o (settled)
  );

  pwr_seq_fsm #(.DRAIN_CYC(DRAIN_CYC)) i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ext_rst_i     (ext_rst_i),
    .req_idle_i    (req_idle_i),
    .req_pd_i      (req_pd_i),
    .wake_i        (wake),
    .settled_i     (settled),
    .cpu_clk_en_o  (cpu_clk_en_o),
    .per_clk_en_o  (per_clk_en_o),
    .osc_en_o      (osc_en_o),
    .ram_inhibit_o (ram_inhibit_o),
    .core_rst_o    (core_rst_o),
    .idle_o        (idle_o),
    .pd_o          (pd_o)
  );
endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ   = 8;
  localparam int SETTLE = 8;
  localparam int DRAIN  = 2;

  // vector order: cpu, per, osc, ram_inh, core_rst, idle, pd
  localparam logic [6:0] V_RUN   = 7'b1110000;
  localparam logic [6:0] V_RSTU  = 7'b0010100;
  localparam logic [6:0] V_RSTS  = 7'b1110100;
  localparam logic [6:0] V_IDLE  = 7'b0110010;
  localparam logic [6:0] V_PD    = 7'b0000001;
  localparam logic [6:0] V_DRAIN = 7'b1111000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_rst = 1'b0, req_idle = 1'b0, req_pd = 1'b0;
  logic [NIRQ-1:0] pend = '0, en = '0;
  logic cpu_en, per_en, osc_en, ram_inh, core_rst, idle_f, pd_f;

  int n_chk = 0, n_fail = 0;
  string       q_tag[$];
  logic [6:0]  q_exp[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.NUM_IRQ(NIRQ), .SETTLE_CYC(SETTLE), .DRAIN_CYC(DRAIN)) i_pwr_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ext_rst_i(ext_rst),
    .req_idle_i(req_idle), .req_pd_i(req_pd),
    .irq_pend_i(pend), .irq_en_i(en),
    .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en), .osc_en_o(osc_en),
    .ram_inhibit_o(ram_inh), .core_rst_o(core_rst), .idle_o(idle_f), .pd_o(pd_f)
  );

  function automatic logic [6:0] outs();
    return {cpu_en, per_en, osc_en, ram_inh, core_rst, idle_f, pd_f};
  endfunction

  task automatic compare(string tag, logic [6:0] exp);
    n_chk++;
    if (outs() !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, outs(), exp);
    end
  endtask

  // monitor: pops one expected item per cycle, mid-cycle
  always @(negedge clk) begin
    if (q_exp.size() != 0) compare(q_tag.pop_front(), q_exp.pop_front());
  end

  // driver: inputs already applied; expect value after the next edge
  task automatic cyc(string tag, logic [6:0] exp);
    @(posedge clk);
    #1;
    q_tag.push_back(tag);
    q_exp.push_back(exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    compare("R1 in reset", V_RSTU);
    @(negedge clk) rst_n = 1'b1;
    // R1 power-on settle
    for (int k = 1; k < SETTLE; k++) cyc("R1 settling", V_RSTU);
    cyc("R1 settled", V_RSTS);
    cyc("R1 running", V_RUN);
    // R3 idle entry
    req_idle = 1'b1; cyc("R3 idle", V_IDLE); req_idle = 1'b0;
    // R5 pending but masked
    pend = 8'h01; en = 8'h02;
    for (int k = 0; k < 3; k++) cyc("R5 masked irq", V_IDLE);
    // R11 pd request in idle ignored
    req_pd = 1'b1; cyc("R11 req in idle", V_IDLE); req_pd = 1'b0;
    // R4 enabled wake
    en = 8'h03; cyc("R4 wake", V_RUN); pend = '0;
    // R2 both requests
    req_idle = 1'b1; req_pd = 1'b1; cyc("R2 pd priority", V_PD);
    req_idle = 1'b0; req_pd = 1'b0;
    // R6 interrupts ignored
    pend = '1; en = '1;
    for (int k = 0; k < 3; k++) cyc("R6 pd no wake", V_PD);
    req_idle = 1'b1; cyc("R11 req in pd", V_PD); req_idle = 1'b0;
    // R7 reset pulse from power-down
    ext_rst = 1'b1; cyc("R7 osc on", V_RSTU); ext_rst = 1'b0;
    for (int k = 1; k < SETTLE; k++) cyc("R7 settling", V_RSTU);
    cyc("R7 settled", V_RSTS);
    cyc("R7 running", V_RUN);
    pend = '0;
    // R8 long reset while running
    ext_rst = 1'b1;
    for (int k = 0; k < 3; k++) cyc("R8 held", V_RSTS);
    ext_rst = 1'b0; cyc("R8 release", V_RUN);
    // R9 reset ends idle
    req_idle = 1'b1; cyc("R9 idle", V_IDLE); req_idle = 1'b0;
    ext_rst = 1'b1; cyc("R9 inhibit 1", V_DRAIN); ext_rst = 1'b0;
    cyc("R9 inhibit 2", V_DRAIN);
    cyc("R9 core reset", V_RSTS);
    cyc("R9 running", V_RUN);
    // R10 reset and wake together
    req_idle = 1'b1; cyc("R10 idle", V_IDLE); req_idle = 1'b0;
    pend = 8'h80; en = 8'h80; ext_rst = 1'b1;
    cyc("R10 reset wins", V_DRAIN);
    ext_rst = 1'b0; pend = '0;
    cyc("R10 inhibit 2", V_DRAIN);
    cyc("R10 core reset", V_RSTS);
    cyc("R10 running", V_RUN);
    @(posedge clk);
    @(posedge clk);
    finish_run();
  end
endmodule